// File: doc/BRIEF.md
# Phase-Shifted Pseudo-Random Scan Pattern Source

This block produces five pseudo-random bit streams for five scan chains. A 4-bit maximal-length shift register with characteristic polynomial x^4+x+1 steps through all fifteen non-zero states. A small XOR network then turns its stages into five channels. Each channel carries the same length-15 sequence as the first channel, advanced by a fixed number of clocks. Neighbouring chains therefore no longer receive copies of one another that are only one position apart.

The register has stages x1..x4, held in `state[0]`..`state[3]`. On each step every stage takes the value of the stage above it, x1 <- x2, x2 <- x3 and x3 <- x4. The top stage takes x1 XOR x2. Channel 1 is x1, so channel 1 at cycle t+k equals x(k+1) at cycle t for k = 0..3. The other channels are built from four XOR gates:
- channel 2 = x3^x4
- channel 3 = x1^x2
- channel 4 = channel 2 ^ channel 3
- channel 5 = channel 3 ^ x4

These gates give each channel a lead over channel 1 of 0, 6, 4, 12 and 7 steps respectively. The taps come from the dual register, which uses internal feedback and the same polynomial. That register is started from a single 1 and clocked j times, and its contents mark the stages that combine to a phase of j.

Top module: `lfsr_phase_shifter`

## Requirements
- R1: After reset the register holds x1=1 and x2=x3=x4=0, and the channel outputs `chan[4:0]` (bit 0 = channel 1) read 5'b11101.
- R2: When `seed_load` is high at a clock edge with a non-zero `seed`, the register takes `seed` (bit 0 -> x1). Channel 1 over that cycle and the next three steps then reads `seed[0]`, `seed[1]`, `seed[2]`, `seed[3]`.
- R3: Loading an all-zero `seed` sets the register to x1=1, x2=x3=x4=0 instead, so `chan` reads 5'b11101.
- R4: `seed_load` takes priority over `step_en` when both are high at the same edge.
- R5: With `seed_load` and `step_en` both low, the state and all channel outputs hold their values.
- R6: With `step_en` high, channel 1 follows s(t+4) = s(t+1) XOR s(t), and the 5-bit channel word repeats with period exactly 15 through 15 distinct values.
- R7: At every step t, channel k equals channel 1 at step t+d_k mod 15, with d = 0, 6, 4, 12, 7 for channels 1 to 5.
- R8: The register never holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance the register by one step |
| seed_load | input | 1 | Load `seed` into the register (priority over stepping) |
| seed | input | 4 | Seed value, bit 0 goes to stage x1 |
| chan | output | 5 | Phase-shifted channel outputs, bit 0 = channel 1 |

## Verification
The embedded assertions check the following on every cycle:
- the hold behaviour when idle;
- that a seed load lands in x1;
- the zero-seed replacement;
- the one-place shift on each step;
- that the register never reaches the all-zero state.

The phase relations between channels span up to 12 steps, so only the bench's scenarios can show them. The same holds for the period and distinctness of the sequence and for the full readout of a loaded seed. The bench records a long run of channel 1 and compares every other channel against its advanced copy. It also loads all sixteen seed values and reads each one back bit by bit.

// File: rtl/lfsr_phase_shifter.sv
module lfsr_phase_shifter #(
  parameter logic [3:0] SAFE_SEED = 4'b0001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_en,
  input  logic       seed_load,
  input  logic [3:0] seed,
  output logic [4:0] chan
);

  logic [3:0] state;
  logic       fb;
  logic       c2, c3;

  assign fb = state[0] ^ state[1];

  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= SAFE_SEED;
    else if (seed_load)
      state <= (seed == 4'b0000) ? SAFE_SEED : seed;
    else if (step_en)
      state <= {fb, state[3:1]};
  end

  assign c2 = state[2] ^ state[3];
  assign c3 = state[0] ^ state[1];

  assign chan[0] = state[0];
  assign chan[1] = c2;
  assign chan[2] = c3;
  assign chan[3] = c2 ^ c3;
  assign chan[4] = c3 ^ state[3];

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !step_en) |=> $stable(chan));

  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed != 4'b0000) |=> chan[0] == $past(seed[0]));

  a_r3_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed == 4'b0000) |=> chan == 5'b11101);

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !seed_load) |=> chan[0] == $past(state[1]));

  a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state != 4'b0000);

endmodule

// File: tb/lfsr_phase_shifter_tb.sv
module lfsr_phase_shifter_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en;
  logic       seed_load;
  logic [3:0] seed;
  logic [4:0] chan;

  int checks = 0;
  int errors = 0;

  lfsr_phase_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .seed_load(seed_load), .seed(seed), .chan(chan)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  int   d [5] = '{0, 6, 4, 12, 7};
  logic s   [48];
  logic [4:0] word [48];

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b0; seed_load = 1'b0; seed = 4'b0;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", chan, 5'b11101);

    // expected channel-1 stream from the recurrence, seeded with reset state 1,0,0,0
    s[0] = 1'b1; s[1] = 1'b0; s[2] = 1'b0; s[3] = 1'b0;
    for (int t = 0; t + 4 < 48; t++) s[t+4] = s[t+1] ^ s[t];

    step_en = 1'b1;
    for (int t = 0; t < 48; t++) begin
      word[t] = chan;
      check("R6 channel 1 recurrence", chan[0], s[t]);
      tick();
    end
    step_en = 1'b0;

    for (int i = 0; i < 15; i++)
      for (int j = i + 1; j < 15; j++)
        if (word[i] == word[j]) check("R6 distinct words", word[j], ~word[i]);
    check("R6 period 15", word[15], word[0]);
    check("R6 period 15 again", word[30], word[15]);
    for (int t = 0; t < 15; t++) check("R8 nonzero word", (word[t] != 5'b0), 1);

    for (int t = 0; t < 30; t++)
      for (int k = 1; k < 5; k++)
        check($sformatf("R7 channel %0d phase", k + 1), word[t][k], word[t + d[k]][0]);

    begin
      logic [4:0] held;
      held = chan;
      for (int n = 0; n < 6; n++) begin
        tick();
        check("R5 hold while idle", chan, held);
      end
    end

    for (int v = 0; v < 16; v++) begin
      logic [3:0] e;
      e = (v == 0) ? 4'b0001 : 4'(v);
      seed = 4'(v); seed_load = 1'b1; step_en = v[0];
      tick();
      seed_load = 1'b0; step_en = 1'b1;
      if (v == 0) check("R3 zero seed word", chan, 5'b11101);
      for (int b = 0; b < 4; b++) begin
        check(v[0] ? "R4 load over step" : "R2 seed readout", chan[0], e[b]);
        tick();
      end
      step_en = 1'b0;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule